// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an asynchronous static RAM. The host raises a request with an address, a read/write flag and (for writes) a data word. The controller then produces the active-low chip-enable, write-enable and output-enable strobes, holds the address, and steers a split bidirectional data bus (out, in, output-enable). Every interval is a whole number of clock cycles. Each count is the ceiling of a required minimum time divided by the clock period, and never less than one cycle. A parameter selects a fast (70 ns class) or slow (100 ns class) set of minimum times.

The controller is a six-state machine.

- IDLE waits for a request. It takes READ to RD_ACCESS and WRITE to WR_FLOAT.
- RD_ACCESS holds CE and OE low for the access time. On its last edge it samples the data and returns to IDLE with an acknowledge.
- WR_FLOAT pulls CE and WE low while the data driver stays off. WR_DRIVE then turns the driver on for the data setup time.
- WR_HOLD raises WE while CE stays low and the data is still driven, so WE rising is the edge that ends the write. It goes to WR_RECOVER when the cycle-time minimum needs padding, otherwise to IDLE with the acknowledge.
- WR_RECOVER keeps every strobe high until the write cycle time is met.

OE stays high during writes. The acknowledge is one cycle wide. A request seen in the acknowledge cycle is not taken.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and after it is released, CE, WE and OE are high (1), the data driver enable is 0 and the acknowledge is 0.
- R2: A read holds CE and OE low for exactly 7 cycles (fast grade, 10 ns clock). It samples the memory data on the edge that ends them, and the acknowledge and the read data are valid together in the next cycle.
- R3: A write holds CE low for 7 cycles and WE low for 6 of them, and OE stays high for the whole write.
- R4: During a write the driver is off for the first 3 cycles of WE low. It is on for the last 3 cycles of WE low and for the single cycle after WE rises, so data is set up at least 3 cycles before the terminating edge.
- R5: Every write is ended by WE rising while CE is still low. CE rises exactly one cycle later.
- R6: The memory address does not change while CE stays low.
- R7: The acknowledge is high for exactly one cycle per access. A request still asserted during the acknowledge cycle does not start a new access.
- R8: The data driver is never enabled while OE is low.
- R9: Data written to an address is returned by later reads of that address until it is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid with host_ack |
| host_ack | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data driven toward memory |
| mem_din | input | DATA_W | Data from memory |
| mem_dout_en | output | 1 | Data driver enable |

## Verification
The main function is driven in several patterns:

- writes to the lowest, highest and interior addresses with all-zero, all-one and mixed data;
- reads of written and never-written cells;
- an overwrite followed by a read-back;
- an acknowledge held against a lingering request.

The memory model in the bench returns a decoy value until CE and OE have been low for 7 cycles, which exposes a read that is sampled too early. It stores the decoy instead of the data when the driver is off at the WE rising edge, which exposes a wrong setup window. The per-strobe low-cycle counts separate a shortened pulse from a wrongly ordered termination.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RD_ACCESS  = 3'd1,
        ST_WR_FLOAT   = 3'd2,
        ST_WR_DRIVE   = 3'd3,
        ST_WR_HOLD    = 3'd4,
        ST_WR_RECOVER = 3'd5
    } ctl_state_t;

    // ceiling of a time over the clock period, at least one cycle
    function automatic int unsigned to_cycles(input int unsigned t_ns, input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              sample,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] in_mem,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata,
    output logic [DATA_W-1:0] out_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_addr  <= '0;
            out_wdata <= '0;
            out_rdata <= '0;
        end else begin
            if (capture) begin
                out_addr  <= in_addr;
                out_wdata <= in_wdata;
            end
            if (sample) begin
                out_rdata <= in_mem;
            end
        end
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 10,
    parameter bit SLOW_GRADE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ack,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_dout_en
);
    // minimum times per grade, in ns
    localparam int unsigned T_CYCLE  = SLOW_GRADE ? 100 : 70;
    localparam int unsigned T_ACCESS = SLOW_GRADE ? 100 : 70;
    localparam int unsigned T_OE_ACC = SLOW_GRADE ? 75  : 35;
    localparam int unsigned T_WE_PW  = SLOW_GRADE ? 80  : 50;
    localparam int unsigned T_ADR_WE = SLOW_GRADE ? 90  : 60;
    localparam int unsigned T_CE_WE  = SLOW_GRADE ? 90  : 60;
    localparam int unsigned T_DSETUP = SLOW_GRADE ? 60  : 30;
    localparam int unsigned T_FLOAT  = SLOW_GRADE ? 50  : 25;

    // derived cycle counts
    localparam int unsigned RD_N   = max2(max2(to_cycles(T_ACCESS, CLK_NS), to_cycles(T_OE_ACC, CLK_NS)),
                                          to_cycles(T_CYCLE, CLK_NS));
    localparam int unsigned FLT_N  = to_cycles(T_FLOAT, CLK_NS);
    localparam int unsigned WLOW_N = max2(max2(to_cycles(T_WE_PW, CLK_NS), to_cycles(T_ADR_WE, CLK_NS)),
                                          to_cycles(T_CE_WE, CLK_NS));
    localparam int unsigned SD_N   = to_cycles(T_DSETUP, CLK_NS);
    localparam int unsigned DRV_N  = max2(SD_N, (WLOW_N > FLT_N) ? (WLOW_N - FLT_N) : 1);
    localparam int unsigned WUSE_N = FLT_N + DRV_N + 1;
    localparam int unsigned WC_N   = to_cycles(T_CYCLE, CLK_NS);
    localparam int unsigned REC_N  = (WC_N > WUSE_N) ? (WC_N - WUSE_N) : 0;
    localparam int unsigned MAXC   = max2(max2(RD_N, FLT_N), max2(DRV_N, max2(REC_N, 1)));
    localparam int          CW     = $clog2(MAXC + 1);

    ctl_state_t    state, state_nx;
    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_val;
    logic          accept, sample, ack_nx;

    sram_ctl_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .capture   (accept),
        .sample    (sample),
        .in_addr   (host_addr),
        .in_wdata  (host_wdata),
        .in_mem    (mem_din),
        .out_addr  (mem_addr),
        .out_wdata (mem_dout),
        .out_rdata (host_rdata)
    );

    assign accept = (state == ST_IDLE) && host_req && !host_ack;
    assign sample = (state == ST_RD_ACCESS) && tmr_done;

    // next state and phase timer loading
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ack_nx   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (host_we) begin
                        state_nx = ST_WR_FLOAT;
                        tmr_val  = CW'(FLT_N - 1);
                    end else begin
                        state_nx = ST_RD_ACCESS;
                        tmr_val  = CW'(RD_N - 1);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_done) begin
                    state_nx = ST_IDLE;
                    ack_nx   = 1'b1;
                end
            end
            ST_WR_FLOAT: begin
                if (tmr_done) begin
                    state_nx = ST_WR_DRIVE;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(DRV_N - 1);
                end
            end
            ST_WR_DRIVE: begin
                if (tmr_done) begin
                    state_nx = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                if (REC_N > 0) begin
                    state_nx = ST_WR_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = CW'((REC_N > 0) ? REC_N - 1 : 0);
                end else begin
                    state_nx = ST_IDLE;
                    ack_nx   = 1'b1;
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_done) begin
                    state_nx = ST_IDLE;
                    ack_nx   = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // registered strobes decoded from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ce_n    <= 1'b1;
            mem_we_n    <= 1'b1;
            mem_oe_n    <= 1'b1;
            mem_dout_en <= 1'b0;
            host_ack    <= 1'b0;
        end else begin
            mem_ce_n    <= !(state_nx inside {ST_RD_ACCESS, ST_WR_FLOAT, ST_WR_DRIVE, ST_WR_HOLD});
            mem_we_n    <= !(state_nx inside {ST_WR_FLOAT, ST_WR_DRIVE});
            mem_oe_n    <= (state_nx != ST_RD_ACCESS);
            mem_dout_en <= (state_nx inside {ST_WR_DRIVE, ST_WR_HOLD});
            host_ack    <= ack_nx;
        end
    end
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W     = 15,
    parameter int CLK_NS     = 10,
    parameter bit SLOW_GRADE = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              host_ack,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dout_en
);
    localparam int unsigned SETUP_MIN =
        sram_ctl_pkg::to_cycles(SLOW_GRADE ? 60 : 30, CLK_NS);

    logic [7:0] drv_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            drv_run <= '0;
        end else if (!mem_dout_en) begin
            drv_run <= '0;
        end else if (drv_run != 8'hFF) begin
            drv_run <= drv_run + 1'b1;
        end
    end

    // R8
    no_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_dout_en && !mem_oe_n));

    // R5
    we_ends_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_ce_n);

    // R5
    ce_after_we_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |=> $rose(mem_ce_n));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R7
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    // R3
    oe_high_write_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    // R4
    float_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> !mem_dout_en);

    // R4
    setup_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dout_en && drv_run >= 8'(SETUP_MIN)));
endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .SLOW_GRADE(SLOW_GRADE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_ack    (host_ack),
    .mem_ce_n    (mem_ce_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_addr    (mem_addr),
    .mem_dout_en (mem_dout_en)
);

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
    localparam int AW = 5;
    localparam int DW = 8;
    localparam logic [DW-1:0] DECOY = 8'hA5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_ack;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout, mem_din;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(10), .SLOW_GRADE(1'b0)) dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ack(host_ack), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_din(mem_din), .mem_dout_en(mem_dout_en)
    );

    // memory model: decoy until 7 cycles of CE and OE low
    logic [DW-1:0] mem [0:(1<<AW)-1];
    int rd_run = 0;
    initial for (int i = 0; i < (1<<AW); i++) mem[i] = 8'h11;

    always @(negedge clk) begin
        if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0) rd_run <= rd_run + 1;
        else rd_run <= 0;
    end
    assign mem_din = (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && rd_run >= 7) ? mem[mem_addr] : DECOY;

    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0) mem[mem_addr] = mem_dout_en ? mem_dout : DECOY;
    end

    // strobe monitor
    bit mon_on = 0;
    int n_ce, n_oe, n_we, n_drv, n_flt, n_tail, n_ack, n_clash, n_amove;
    logic [AW-1:0] last_addr;
    logic          last_ce_low = 1'b0;
    always @(negedge clk) begin
        if (mem_dout_en && !mem_oe_n) n_clash++;
        if (mon_on) begin
            if (!mem_ce_n) n_ce++;
            if (!mem_oe_n) n_oe++;
            if (!mem_we_n) n_we++;
            if (mem_dout_en) n_drv++;
            if (!mem_we_n && !mem_dout_en) n_flt++;
            if (!mem_ce_n && mem_we_n && mem_oe_n) n_tail++;
            if (host_ack) n_ack++;
            if (!mem_ce_n && last_ce_low && mem_addr != last_addr) n_amove++;
        end
        last_ce_low = !mem_ce_n;
        last_addr   = mem_addr;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit linger, output logic [DW-1:0] got);
        int cyc = 0;
        n_ce = 0; n_oe = 0; n_we = 0; n_drv = 0; n_flt = 0; n_tail = 0; n_ack = 0; n_amove = 0;
        mon_on = 1;
        host_we = we; host_addr = a; host_wdata = d; host_req = 1'b1;
        do begin
            @(negedge clk);
            cyc++;
        end while (!host_ack && cyc < 100);
        got = host_rdata;
        if (cyc >= 100) chk("R7", "watchdog ack", 0, 1);
        if (linger) begin
            @(negedge clk);
            chk("R7", "request in ack cycle ignored, ce_n", int'(mem_ce_n), 1);
        end
        host_req = 1'b0;
        repeat (3) @(negedge clk);
        mon_on = 0;
        chk("R7", "ack width", n_ack, 1);
        chk(we ? "R3" : "R2", "ce low cycles", n_ce, 7);
        chk(we ? "R3" : "R2", "oe low cycles", n_oe, we ? 0 : 7);
        chk("R3", "we low cycles", n_we, we ? 6 : 0);
        chk("R4", "driver cycles", n_drv, we ? 4 : 0);
        chk("R4", "float cycles", n_flt, we ? 3 : 0);
        chk("R5", "ce low after we rise", n_tail, we ? 1 : 0);
        chk("R6", "address moves under ce", n_amove, 0);
    endtask

    typedef struct packed {
        logic          we;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 5'd3,  8'h3C},
        '{1'b1, 5'd0,  8'h00},
        '{1'b1, 5'd31, 8'hFF},
        '{1'b1, 5'd17, 8'h81},
        '{1'b0, 5'd3,  8'h3C},
        '{1'b0, 5'd0,  8'h00},
        '{1'b0, 5'd31, 8'hFF},
        '{1'b0, 5'd17, 8'h81},
        '{1'b0, 5'd9,  8'h11},
        '{1'b1, 5'd3,  8'h7E},
        '{1'b0, 5'd3,  8'h7E}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk("R7", "global watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] got;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1", "ce_n in reset", int'(mem_ce_n), 1);
        chk("R1", "we_n in reset", int'(mem_we_n), 1);
        chk("R1", "oe_n in reset", int'(mem_oe_n), 1);
        chk("R1", "driver in reset", int'(mem_dout_en), 0);
        chk("R1", "ack in reset", int'(host_ack), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "strobes after reset", int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
        chk("R1", "driver/ack after reset", int'({mem_dout_en, host_ack}), 0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].a, VECS[i].d, 1'b0, got);
            if (!VECS[i].we) chk("R9", $sformatf("read data vector %0d", i), int'(got), int'(VECS[i].d));
        end

        // R7 lingering request during ack, then read back (R2 timing via decoy)
        access(1'b1, 5'd12, 8'hC3, 1'b1, got);
        access(1'b0, 5'd12, 8'h00, 1'b1, got);
        chk("R2", "read after lingering write", int'(got), 8'hC3);
        chk("R9", "neighbour untouched", int'(mem[13]), 8'h11);

        chk("R8", "driver while oe low", n_clash, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule